// File: doc/BRIEF.md
# Card Bus Master Cycle Controller

This block is the host-side engine of a single-master card bus with three card slots. It takes byte or word read and write requests from an internal valid/ready port and turns each one into one bus cycle. A cycle pulls one active-low select low and drives the word address, the data lanes and the read or write strobes. It completes when that select rises, and the slave commits the transfer on that rising edge. Each slot keeps its own settings: cycle length in wait states, the minimum time its select must stay high between cycles, and whether it accepts burst cycles.

The controller is an FSM with three states. `ST_IDLE` drives every select high. `ST_ACTIVE` holds one select low with RD or the write strobes asserted for a wait-state count. `ST_TURN` is the one-cycle break between write-burst beats: the select stays low, the write strobes go high and the new address and data appear. The transitions are:
- *start*: `ST_IDLE` to `ST_ACTIVE` on an accepted request.
- *hold*: `ST_ACTIVE` to `ST_ACTIVE` while the wait count is non-zero.
- *read-chain*: `ST_ACTIVE` to `ST_ACTIVE` when the last wait cycle accepts a burst read beat.
- *write-chain*: `ST_ACTIVE` to `ST_TURN` when the last wait cycle accepts a burst write beat.
- *resume*: `ST_TURN` to `ST_ACTIVE`.
- *finish*: `ST_ACTIVE` to `ST_IDLE` when the last wait cycle accepts nothing.

Read data is returned on a response strobe one cycle after the select rises, with byte reads aligned to the low lane. The interrupt inputs of the three slots pass through a two-stage synchronizer.

Top module: `cardbus_master`

## Requirements
- R1: During and right after reset, all of `bus_sel_n` are high, `bus_rd_n`, `bus_lwr_n` and `bus_hwr_n` are high, and `bus_doe` and `rsp_valid` are low.
- R2: At most one `bus_sel_n` bit is low at any time. Whenever all selects are high, RD and both write strobes are high.
- R3: A non-burst cycle holds the selected slot's `bus_sel_n[slot]` low for exactly wait+1 clock cycles, where wait is that slot's programmed wait-state count. RD is low for that whole time on a read and high on a write.
- R4: Writes drive the strobes and lanes by size. A word write (`req_word`=1) pulls both strobes low and drives `req_wdata` unchanged. A byte write drives `{req_wdata[7:0], req_wdata[7:0]}`, pulls only `bus_lwr_n` low when `req_odd`=0 and only `bus_hwr_n` low when `req_odd`=1. `bus_doe` is high exactly while a write cycle holds its select low. RD and a write strobe are never low together.
- R5: `rsp_valid` pulses in the first cycle after each beat ends. For a read, `rsp_rdata` is `bus_din` sampled in the beat's last cycle: unchanged for a word (`req_odd` is then ignored), `{8'h00, bus_din[7:0]}` for an even byte, and `{8'h00, bus_din[15:8]}` for an odd byte.
- R6: `bus_addr` carries `req_addr` as a word address. `bus_addr` and `bus_dout` do not change on the cycle in which the select rises. They also do not change while a write strobe stays low.
- R7: After a cycle to slot s ends, the select of slot s stays high for at least gap(s)+1 cycles before the next cycle to s. A request to a different slot is accepted in the first idle cycle.
- R8: If burst is enabled for the slot, a read request to the same slot presented during the last wait cycle continues the burst. The select and RD stay low, the address changes, the next beat again lasts wait+1 cycles, and each beat yields its own response.
- R9: A write burst to a burst-enabled slot keeps the select low. The write strobes go high for exactly one cycle between beats, and the new address and data are presented in that cycle.
- R10: For a slot with burst disabled, back-to-back requests always leave its select high between cycles.
- R11: A request whose `req_slot` is 3 or above is never accepted. `req_ready` stays low and no select falls.
- R12: `irq_pend[i]` goes high two clock edges after `irq_n[i]` is driven low.
- R13: After reset every slot has a wait count of all ones (16 select-low cycles with the default width), a gap of zero and burst disabled. A `cfg_we` write with `cfg_slot`=i replaces the settings of slot i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a slot's settings |
| cfg_slot | input | SLOT_W | Slot whose settings are written |
| cfg_wait | input | WAIT_W | Wait states; select-low cycles = value+1 |
| cfg_gap | input | GAP_W | Extra idle cycles required between cycles to the slot |
| cfg_burst | input | 1 | Allow burst cycles to the slot |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_slot | input | SLOT_W | Target slot |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_odd | input | 1 | Byte lane for byte accesses, 1 = upper byte |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data; byte writes use bits 7:0 |
| rsp_valid | output | 1 | One-cycle pulse per completed beat |
| rsp_rdata | output | 16 | Aligned read data, zero for writes |
| bus_sel_n | output | NSLOT | Active-low slot selects |
| bus_addr | output | AW | Bus word address |
| bus_dout | output | 16 | Bus write data |
| bus_doe | output | 1 | Enable for the bus data drivers |
| bus_din | input | 16 | Bus read data |
| bus_rd_n | output | 1 | Active-low read |
| bus_lwr_n | output | 1 | Active-low write strobe, low byte |
| bus_hwr_n | output | 1 | Active-low write strobe, high byte |
| irq_n | input | NSLOT | Active-low slot interrupts |
| irq_pend | output | NSLOT | Synchronized active-high interrupt pending |

## Verification
The hardest case to reach is a burst continuation. The bench must present a second, matching request exactly while the first beat sits in its last wait cycle. Otherwise the chain case looks just like two separate cycles. The pair sequences keep `req_valid` asserted with the follow-on request from the cycle after the first handshake, so `req_ready` rises on its own at the chain point. They then count the select-low run, the cycles the strobes spend high inside that run, and the response pulses. The same pair driver measures the idle spacing imposed by each slot's gap, and it shows a gap that blocks its own slot while another slot starts at once.

// File: rtl/cbm_pkg.sv
package cbm_pkg;

    // Bus engine states; ST_TURN is the strobe-high break inside a write burst.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_TURN   = 2'd2
    } cbm_state_t;

    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;

endpackage

// File: rtl/cbm_slot_cfg.sv
module cbm_slot_cfg #(
    parameter int NSLOT  = 3,
    parameter int SLOT_W = 2,
    parameter int WAIT_W = 4,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_burst,
    output logic [WAIT_W-1:0] wait_o  [NSLOT],
    output logic [GAP_W-1:0]  gap_o   [NSLOT],
    output logic [NSLOT-1:0]  burst_o
);

    // One register set per slot; an out-of-range slot matches none.
    for (genvar i = 0; i < NSLOT; i++) begin : g_slot
        logic hit;
        assign hit = cfg_we && (int'(cfg_slot) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wait_o[i]  <= '1;
                gap_o[i]   <= '0;
                burst_o[i] <= 1'b0;
            end else if (hit) begin
                wait_o[i]  <= cfg_wait;
                gap_o[i]   <= cfg_gap;
                burst_o[i] <= cfg_burst;
            end
        end
    end

endmodule

// File: rtl/cbm_gap_timer.sv
module cbm_gap_timer #(
    parameter int GAP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [GAP_W-1:0] load_val,
    output logic             open
);

    logic [GAP_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign open = (cnt == '0);

endmodule

// File: rtl/cbm_lane.sv
module cbm_lane
    import cbm_pkg::*;
(
    input  logic              word,
    input  logic              odd,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              lo_en,
    output logic              hi_en,
    output logic [DATA_W-1:0] rdata
);

    // Write side: a byte is copied onto both lanes, the strobe picks the lane.
    always_comb begin
        if (word) begin
            dout  = wdata;
            lo_en = 1'b1;
            hi_en = 1'b1;
        end else begin
            dout  = {wdata[LANE_W-1:0], wdata[LANE_W-1:0]};
            lo_en = !odd;
            hi_en = odd;
        end
    end

    // Read side: byte reads are brought down to the low lane.
    always_comb begin
        if (word) begin
            rdata = din;
        end else if (odd) begin
            rdata = {{LANE_W{1'b0}}, din[DATA_W-1:LANE_W]};
        end else begin
            rdata = {{LANE_W{1'b0}}, din[LANE_W-1:0]};
        end
    end

endmodule

// File: rtl/cbm_irq_sync.sv
module cbm_irq_sync #(
    parameter int NSLOT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSLOT-1:0] irq_n,
    output logic [NSLOT-1:0] irq_pend
);

    logic [NSLOT-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1   <= '0;
            irq_pend <= '0;
        end else begin
            stage1   <= ~irq_n;
            irq_pend <= stage1;
        end
    end

endmodule

// File: rtl/cardbus_master.sv
module cardbus_master
    import cbm_pkg::*;
#(
    parameter int NSLOT  = 3,
    parameter int SLOT_W = 2,
    parameter int AW     = 16,
    parameter int WAIT_W = 4,
    parameter int GAP_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [WAIT_W-1:0] cfg_wait,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_burst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SLOT_W-1:0] req_slot,
    input  logic              req_write,
    input  logic              req_word,
    input  logic              req_odd,
    input  logic [AW-1:0]     req_addr,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [NSLOT-1:0]  bus_sel_n,
    output logic [AW-1:0]     bus_addr,
    output logic [15:0]       bus_dout,
    output logic              bus_doe,
    input  logic [15:0]       bus_din,
    output logic              bus_rd_n,
    output logic              bus_lwr_n,
    output logic              bus_hwr_n,
    input  logic [NSLOT-1:0]  irq_n,
    output logic [NSLOT-1:0]  irq_pend
);

    localparam int SLOT_SPAN = 1 << SLOT_W;

    // ---------------------------------------------------------------
    // Per-slot settings and idle-gap timers
    // ---------------------------------------------------------------
    logic [WAIT_W-1:0] wait_cfg [NSLOT];
    logic [GAP_W-1:0]  gap_cfg  [NSLOT];
    logic [NSLOT-1:0]  burst_cfg;

    cbm_slot_cfg #(
        .NSLOT (NSLOT),
        .SLOT_W(SLOT_W),
        .WAIT_W(WAIT_W),
        .GAP_W (GAP_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_slot (cfg_slot),
        .cfg_wait (cfg_wait),
        .cfg_gap  (cfg_gap),
        .cfg_burst(cfg_burst),
        .wait_o   (wait_cfg),
        .gap_o    (gap_cfg),
        .burst_o  (burst_cfg)
    );

    cbm_state_t        state_q, state_d;
    logic [SLOT_W-1:0] cur_slot;
    logic              cur_write;
    logic              cur_word;
    logic              cur_odd;
    logic [AW-1:0]     cur_addr;
    logic [15:0]       cur_wdata;
    logic [WAIT_W-1:0] wcnt;

    logic                 beat_last;
    logic                 end_cycle;
    logic [NSLOT-1:0]     gap_open;
    logic [SLOT_SPAN-1:0] gap_open_pad;
    logic [SLOT_SPAN-1:0] burst_pad;

    for (genvar i = 0; i < NSLOT; i++) begin : g_gap
        cbm_gap_timer #(
            .GAP_W(GAP_W)
        ) u_gap (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (end_cycle && (int'(cur_slot) == i)),
            .load_val(gap_cfg[i]),
            .open    (gap_open[i])
        );
    end

    assign gap_open_pad = SLOT_SPAN'(gap_open);
    assign burst_pad    = SLOT_SPAN'(burst_cfg);

    // ---------------------------------------------------------------
    // Request qualification
    // ---------------------------------------------------------------
    logic              slot_ok;
    logic [SLOT_W-1:0] slot_idx;
    logic              start_ready;
    logic              chain_ready;
    logic              accept;

    assign slot_ok   = int'(req_slot) < NSLOT;
    assign slot_idx  = slot_ok ? req_slot : '0;
    assign beat_last = (state_q == ST_ACTIVE) && (wcnt == '0);

    assign start_ready = (state_q == ST_IDLE) && slot_ok && gap_open_pad[req_slot];
    assign chain_ready = beat_last && slot_ok && (req_slot == cur_slot)
                       && (req_write == cur_write) && burst_pad[cur_slot];

    assign req_ready = start_ready || chain_ready;
    assign accept    = req_valid && req_ready;
    assign end_cycle = beat_last && !accept;

    // ---------------------------------------------------------------
    // Next-state logic
    // ---------------------------------------------------------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = ST_ACTIVE;                 // start
                end
            end
            ST_ACTIVE: begin
                if (wcnt != '0) begin
                    state_d = ST_ACTIVE;                 // hold
                end else if (accept) begin
                    state_d = cur_write ? ST_TURN        // write-chain
                                        : ST_ACTIVE;     // read-chain
                end else begin
                    state_d = ST_IDLE;                   // finish
                end
            end
            ST_TURN: begin
                state_d = ST_ACTIVE;                     // resume
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------------------------------------------------------
    // Cycle context and wait counter
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_slot  <= '0;
            cur_write <= 1'b0;
            cur_word  <= 1'b0;
            cur_odd   <= 1'b0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            wcnt      <= '0;
        end else if (accept) begin
            cur_slot  <= slot_idx;
            cur_write <= req_write;
            cur_word  <= req_word;
            cur_odd   <= req_odd;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            wcnt      <= wait_cfg[slot_idx];
        end else if ((state_q == ST_ACTIVE) && (wcnt != '0)) begin
            wcnt <= wcnt - 1'b1;
        end
    end

    // ---------------------------------------------------------------
    // Lane steering
    // ---------------------------------------------------------------
    logic [15:0] lane_dout;
    logic [15:0] lane_rdata;
    logic        lane_lo;
    logic        lane_hi;

    cbm_lane u_lane (
        .word (cur_word),
        .odd  (cur_odd),
        .wdata(cur_wdata),
        .din  (bus_din),
        .dout (lane_dout),
        .lo_en(lane_lo),
        .hi_en(lane_hi),
        .rdata(lane_rdata)
    );

    // Response: captured on the edge that ends each beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= beat_last;
            if (beat_last) begin
                rsp_rdata <= cur_write ? 16'h0000 : lane_rdata;
            end
        end
    end

    // ---------------------------------------------------------------
    // Bus outputs, decoded from state and context
    // ---------------------------------------------------------------
    always_comb begin
        bus_sel_n = '1;
        bus_rd_n  = 1'b1;
        bus_lwr_n = 1'b1;
        bus_hwr_n = 1'b1;
        bus_doe   = 1'b0;
        bus_addr  = cur_addr;
        bus_dout  = lane_dout;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ACTIVE: begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (int'(cur_slot) == i) bus_sel_n[i] = 1'b0;
                end
                bus_rd_n  = cur_write;
                bus_lwr_n = !(cur_write && lane_lo);
                bus_hwr_n = !(cur_write && lane_hi);
                bus_doe   = cur_write;
            end
            ST_TURN: begin
                for (int i = 0; i < NSLOT; i++) begin
                    if (int'(cur_slot) == i) bus_sel_n[i] = 1'b0;
                end
                bus_doe = cur_write;
            end
            default: begin
            end
        endcase
    end

    // ---------------------------------------------------------------
    // Interrupt synchronizer
    // ---------------------------------------------------------------
    cbm_irq_sync #(
        .NSLOT(NSLOT)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n   (irq_n),
        .irq_pend(irq_pend)
    );

endmodule

// File: rtl/cbm_checker.sv
module cbm_checker #(
    parameter int NSLOT = 3,
    parameter int AW    = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             rsp_valid,
    input logic [NSLOT-1:0] bus_sel_n,
    input logic [AW-1:0]    bus_addr,
    input logic [15:0]      bus_dout,
    input logic             bus_rd_n,
    input logic             bus_lwr_n,
    input logic             bus_hwr_n
);

    logic any_sel;
    logic wr_on;
    assign any_sel = ~&bus_sel_n;
    assign wr_on   = !bus_lwr_n || !bus_hwr_n;

    assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_sel_n));

    assert_quiet_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_sel |-> (bus_rd_n && bus_lwr_n && bus_hwr_n));

    assert_no_rd_wr_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && wr_on));

    assert_commit_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(&bus_sel_n) |-> ($stable(bus_addr) && $stable(bus_dout)));

    assert_write_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_on && $past(wr_on)) |-> ($stable(bus_addr) && $stable(bus_dout)));

    assert_accept_selects_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> any_sel);

    assert_rsp_after_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(any_sel));

endmodule

bind cardbus_master cbm_checker #(
    .NSLOT(NSLOT),
    .AW   (AW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .bus_sel_n(bus_sel_n),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_rd_n (bus_rd_n),
    .bus_lwr_n(bus_lwr_n),
    .bus_hwr_n(bus_hwr_n)
);

// File: tb/sim_cardbus_master.sv
`timescale 1ns/1ps
module sim_cardbus_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_slot = '0;
    logic [3:0]  cfg_wait = '0;
    logic [3:0]  cfg_gap = '0;
    logic        cfg_burst = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_slot = '0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic        req_odd = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [2:0]  bus_sel_n;
    logic [15:0] bus_addr;
    logic [15:0] bus_dout;
    logic        bus_doe;
    logic [15:0] bus_din = '0;
    logic        bus_rd_n;
    logic        bus_lwr_n;
    logic        bus_hwr_n;
    logic [2:0]  irq_n = 3'b111;
    logic [2:0]  irq_pend;

    int total = 0;
    int fails = 0;

    always #4 clk = ~clk;

    cardbus_master u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_wait(cfg_wait),
        .cfg_gap(cfg_gap), .cfg_burst(cfg_burst),
        .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
        .req_write(req_write), .req_word(req_word), .req_odd(req_odd),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .bus_sel_n(bus_sel_n), .bus_addr(bus_addr), .bus_dout(bus_dout),
        .bus_doe(bus_doe), .bus_din(bus_din), .bus_rd_n(bus_rd_n),
        .bus_lwr_n(bus_lwr_n), .bus_hwr_n(bus_hwr_n),
        .irq_n(irq_n), .irq_pend(irq_pend)
    );

    // slot, write, word, odd, addr, wdata, din, expected data, lwr, hwr
    typedef struct packed {
        logic [1:0]  slot;
        logic        wr;
        logic        word;
        logic        odd;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] din;
        logic [15:0] exp;
        logic        exp_lo;
        logic        exp_hi;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{2'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0000, 16'hBEEF, 16'hBEEF, 1'b0, 1'b0},
        '{2'd0, 1'b0, 1'b0, 1'b0, 16'h0042, 16'h0000, 16'hBEEF, 16'h00EF, 1'b0, 1'b0},
        '{2'd1, 1'b0, 1'b0, 1'b1, 16'h0043, 16'h0000, 16'hBEEF, 16'h00BE, 1'b0, 1'b0},
        '{2'd2, 1'b1, 1'b1, 1'b0, 16'h5678, 16'hCAFE, 16'h0000, 16'hCAFE, 1'b1, 1'b1},
        '{2'd0, 1'b1, 1'b0, 1'b0, 16'h0100, 16'h00A5, 16'h0000, 16'hA5A5, 1'b1, 1'b0},
        '{2'd1, 1'b1, 1'b0, 1'b1, 16'h0101, 16'h773C, 16'h0000, 16'h3C3C, 1'b0, 1'b1},
        '{2'd2, 1'b0, 1'b1, 1'b1, 16'h2222, 16'h0000, 16'h1357, 16'h1357, 1'b0, 1'b0}
    };

    int slot_wait [3] = '{2, 0, 1};

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input int slot, input int w, input int g, input bit b);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_slot  = 2'(slot);
        cfg_wait  = 4'(w);
        cfg_gap   = 4'(g);
        cfg_burst = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_req(input logic [1:0] slot, input bit wr, input bit word,
                           input bit odd, input logic [15:0] addr, input logic [15:0] wd);
        req_slot  = slot;
        req_write = wr;
        req_word  = word;
        req_odd   = odd;
        req_addr  = addr;
        req_wdata = wd;
    endtask

    // Issue one request; returns at the first negedge after the handshake edge.
    task automatic issue(input logic [1:0] slot, input bit wr, input bit word,
                         input bit odd, input logic [15:0] addr, input logic [15:0] wd);
        @(negedge clk);
        set_req(slot, wr, word, odd, addr, wd);
        req_valid = 1'b1;
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Two requests presented back to back; measures the select pattern.
    task automatic do_pair(input logic [1:0] sa, input logic [1:0] sb, input bit wr,
                           output int low1, output int high_mid, output int low2,
                           output int rsps, output int rd_hi, output int wr_hi);
        int  phase = 0;
        int  stage = 0;
        bit  pend  = 1'b0;
        low1 = 0; high_mid = 0; low2 = 0; rsps = 0; rd_hi = 0; wr_hi = 0;
        @(negedge clk);
        set_req(sa, wr, 1'b1, 1'b0, 16'h0010, 16'h1111);
        req_valid = 1'b1;
        #1;
        if (req_ready) pend = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (rsp_valid) rsps++;
            if (~&bus_sel_n) begin
                if (phase == 0 || phase == 1) begin
                    phase = 1;
                    low1++;
                    if (bus_rd_n) rd_hi++;
                    if (bus_lwr_n) wr_hi++;
                end else if (phase == 2 || phase == 3) begin
                    phase = 3;
                    low2++;
                end
            end else begin
                if (phase == 1 || phase == 2) begin
                    phase = 2;
                    high_mid++;
                end else if (phase == 3) begin
                    phase = 4;
                end
            end
            if (pend) begin
                pend = 1'b0;
                if (stage == 0) begin
                    set_req(sb, wr, 1'b1, 1'b0, 16'h0011, 16'h2222);
                    stage = 1;
                end else begin
                    req_valid = 1'b0;
                    stage = 2;
                end
            end
            #1;
            if (req_valid && req_ready) pend = 1'b1;
        end
        req_valid = 1'b0;
        if (low2 == 0) high_mid = 0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int low;
        int l1, hm, l2, rs, rh, wh;
        bit sel_ok, str_ok, addr_ok, dout_ok;

        // ---------------- reset state (R1)
        repeat (3) @(negedge clk);
        check(bus_sel_n == 3'b111, "R1 sel in reset", 32'(bus_sel_n), 32'h7);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_sel_n == 3'b111 && bus_rd_n && bus_lwr_n && bus_hwr_n,
              "R1 idle strobes", {bus_sel_n, bus_rd_n, bus_lwr_n, bus_hwr_n}, 32'h3F);
        check(!bus_doe && !rsp_valid, "R1 doe/rsp", {bus_doe, rsp_valid}, 32'h0);

        // ---------------- interrupt synchronizer (R12)
        @(negedge clk);
        irq_n = 3'b101;
        @(negedge clk);
        check(irq_pend == 3'b000, "R12 one edge", 32'(irq_pend), 32'h0);
        @(negedge clk);
        check(irq_pend == 3'b010, "R12 two edges", 32'(irq_pend), 32'h2);
        irq_n = 3'b111;

        // ---------------- reset default wait (R13)
        bus_din = 16'h0F0F;
        issue(2'd0, 1'b0, 1'b1, 1'b0, 16'h0001, 16'h0);
        low = 0;
        while (bus_sel_n[0] == 1'b0 && low < 40) begin
            low++;
            @(negedge clk);
        end
        check(low == 16, "R13 default wait", 32'(low), 32'd16);

        // ---------------- program slots
        write_cfg(0, 2, 0, 1'b0);
        write_cfg(1, 0, 3, 1'b0);
        write_cfg(2, 1, 1, 1'b1);
        repeat (6) @(negedge clk);

        // ---------------- vector table (R3 R4 R5 R6)
        for (int v = 0; v < NVEC; v++) begin
            bus_din = VECS[v].din;
            issue(VECS[v].slot, VECS[v].wr, VECS[v].word, VECS[v].odd,
                  VECS[v].addr, VECS[v].wdata);
            low = 0; sel_ok = 1; str_ok = 1; addr_ok = 1; dout_ok = 1;
            while ((~&bus_sel_n) && low < 40) begin
                low++;
                if (bus_sel_n != ~(3'b001 << VECS[v].slot)) sel_ok = 0;
                if (bus_rd_n != VECS[v].wr) str_ok = 0;
                if (bus_lwr_n != !VECS[v].exp_lo) str_ok = 0;
                if (bus_hwr_n != !VECS[v].exp_hi) str_ok = 0;
                if (bus_addr != VECS[v].addr) addr_ok = 0;
                if (bus_doe != VECS[v].wr) dout_ok = 0;
                if (VECS[v].wr && bus_dout != VECS[v].exp) dout_ok = 0;
                @(negedge clk);
            end
            check(low == slot_wait[VECS[v].slot] + 1, "R3 cycle length", 32'(low),
                  32'(slot_wait[VECS[v].slot] + 1));
            check(sel_ok, "R2 select line", 32'(sel_ok), 32'd1);
            check(str_ok, "R4 strobes", 32'(v), 32'(v));
            check(addr_ok, "R6 address", 32'(bus_addr), 32'(VECS[v].addr));
            check(dout_ok, "R4 data lanes", 32'(bus_dout), 32'(VECS[v].exp));
            check(rsp_valid, "R5 response strobe", 32'(rsp_valid), 32'd1);
            if (!VECS[v].wr)
                check(rsp_rdata == VECS[v].exp, "R5 read alignment",
                      32'(rsp_rdata), 32'(VECS[v].exp));
            @(negedge clk);
            check(!rsp_valid, "R5 single pulse", 32'(rsp_valid), 32'd0);
            repeat (5) @(negedge clk);
        end

        // ---------------- burst read on slot 2 (R8)
        do_pair(2'd2, 2'd2, 1'b0, l1, hm, l2, rs, rh, wh);
        check(l1 == 4 && l2 == 0, "R8 burst read select low", 32'(l1), 32'd4);
        check(rh == 0, "R8 burst read RD held", 32'(rh), 32'd0);
        check(rs == 2, "R8 burst read responses", 32'(rs), 32'd2);

        // ---------------- burst write on slot 2 (R9)
        do_pair(2'd2, 2'd2, 1'b1, l1, hm, l2, rs, rh, wh);
        check(l1 == 5 && l2 == 0, "R9 burst write select low", 32'(l1), 32'd5);
        check(wh == 1, "R9 strobe break", 32'(wh), 32'd1);
        check(rs == 2, "R9 burst write responses", 32'(rs), 32'd2);

        // ---------------- no burst on slot 0 (R10)
        do_pair(2'd0, 2'd0, 1'b0, l1, hm, l2, rs, rh, wh);
        check(l1 == 3 && l2 == 3, "R10 separate cycles", 32'(l2), 32'd3);
        check(hm == 1, "R10 select high between", 32'(hm), 32'd1);

        // ---------------- idle gap on slot 1 (R7)
        do_pair(2'd1, 2'd1, 1'b1, l1, hm, l2, rs, rh, wh);
        check(hm == 4, "R7 gap same slot", 32'(hm), 32'd4);
        check(l1 == 1 && l2 == 1, "R7 gap cycle lengths", 32'(l2), 32'd1);
        do_pair(2'd1, 2'd0, 1'b0, l1, hm, l2, rs, rh, wh);
        check(hm == 1, "R7 other slot not blocked", 32'(hm), 32'd1);

        // ---------------- out-of-range slot (R11)
        @(negedge clk);
        set_req(2'd3, 1'b0, 1'b1, 1'b0, 16'h0005, 16'h0);
        req_valid = 1'b1;
        low = 0;
        for (int k = 0; k < 6; k++) begin
            #1;
            if (req_ready) low++;
            @(negedge clk);
            if (bus_sel_n != 3'b111) low++;
        end
        req_valid = 1'b0;
        check(low == 0, "R11 slot 3 refused", 32'(low), 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule